// File: doc/BRIEF.md
# Dual-Priority Transmit Command Scheduler

The scheduler decides which transmit command block the engine works on next. Two command queues are kept, one urgent and one normal. Each queue is a chain of command blocks in memory, and each block is named by its address. A block carries a link to the following block, a byte length and an end-of-chain bit. Software arms a queue by strobing its first address in. The scheduler reads blocks through a simple one-outstanding fetch port and hands each chosen block to the MAC as a command. It reports every finished block on a one-cycle completion pulse.

A read-only pointer register shows the address of the next urgent block that has not yet been started. Reading the register also acts as a fence. Any copy of that block already fetched, or still in flight, is discarded, and the block is read again before it is used. Software can therefore rewrite that block and any later urgent block while the engine keeps running. To hide fetch latency, the scheduler may prefetch the single urgent block at the head of its queue while a command is running. It never fetches further ahead than that.

Top module: `tx_dualq_sched`

## Requirements
- R1: A start strobe loads a queue's head address and marks the queue valid only when that queue is not valid. A strobe on a valid queue is ignored and leaves the head unchanged.
- R2: With `preempt_en` high, each block boundary picks the urgent queue (`cmd_hp`=1) whenever it is valid. Otherwise it picks the normal queue (`cmd_hp`=0).
- R3: With `preempt_en` low, the engine stays on the queue it last took from until that queue is empty, then moves to the other queue. After reset the urgent queue counts as the last one.
- R4: A started command is never preempted. `cmd_valid` stays high and `cmd_addr` stays stable until the cycle `cmd_done` is seen.
- R5: When a block is taken, its queue head becomes the block's link field. The queue stays valid only if the end-of-chain bit (`fetch_eol`=1) was clear. `cmd_len` is the block's length field.
- R6: `ptr_addr` always shows the urgent queue's head and `ptr_empty` shows that the queue is not valid. When the queue is empty, `ptr_addr` holds the link field of the last block taken, which is where the next appended block is expected. Reset gives address 0 and empty.
- R7: After a cycle with `ptr_rd` high, the urgent block at the returned address is used with the memory contents present after that read. Any earlier prefetch of it, and any fetch response arriving in or after that cycle for a request issued before it, is discarded.
- R8: The cycle after `cmd_done` is sampled, `done_valid` pulses for one cycle with the finished block's address on `done_addr` and its queue on `done_hp`.
- R9: `fetch_req` is held with a stable `fetch_addr` until `fetch_ack`. Response data is taken in the ack cycle, and at most one request is outstanding.
- R10: Every fetch address is the current head of a valid queue. Prefetch reaches no further than the head of the urgent queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preempt_en | input | 1 | 1: urgent queue wins at every block boundary |
| hp_start | input | 1 | Start strobe, urgent queue |
| hp_start_addr | input | AW | First block address, urgent queue |
| lp_start | input | 1 | Start strobe, normal queue |
| lp_start_addr | input | AW | First block address, normal queue |
| fetch_req | output | 1 | Block read request |
| fetch_addr | output | AW | Address of the block being read |
| fetch_ack | input | 1 | Read response valid this cycle |
| fetch_next | input | AW | Link field of the block read |
| fetch_len | input | LW | Length field of the block read |
| fetch_eol | input | 1 | End-of-chain bit of the block read |
| cmd_valid | output | 1 | A command is in process |
| cmd_addr | output | AW | Address of the command in process |
| cmd_len | output | LW | Length of the command in process |
| cmd_hp | output | 1 | 1 if the command came from the urgent queue |
| cmd_done | input | 1 | MAC has finished the command |
| done_valid | output | 1 | Completion pulse |
| done_addr | output | AW | Address of the finished block |
| done_hp | output | 1 | Queue of the finished block |
| ptr_rd | input | 1 | Software read of the pointer register (fence) |
| ptr_addr | output | AW | Next urgent block to be processed |
| ptr_empty | output | 1 | Urgent queue holds no pending block |

## Verification
The assertions assume the fetch responder raises `fetch_ack` only while `fetch_req` is high. They also assume the MAC raises `cmd_done` only while `cmd_valid` is high, and that `preempt_en` changes only while nothing is in process. The bench responder acks two cycles into each request. Its MAC model pulses `cmd_done` once after a programmed run length, and `preempt_en` is switched only between idle scenarios. Software rewrites urgent blocks only after reading the pointer register, which is the one condition under which the fence makes a rewrite safe.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  typedef enum logic { Q_HI = 1'b0, Q_LO = 1'b1 } tsq_q_e;

  typedef enum logic [1:0] { ST_IDLE, ST_FETCH, ST_RUN } tsq_st_e;

  // Queue choice at a block boundary. Urgent wins under preemption;
  // otherwise the last served queue is kept until it runs dry.
  function automatic tsq_q_e tsq_pick(input logic preempt, input tsq_q_e last,
                                      input logic hi_v, input logic lo_v);
    if (preempt)      return hi_v ? Q_HI : Q_LO;
    if (last == Q_HI) return hi_v ? Q_HI : Q_LO;
    return lo_v ? Q_LO : Q_HI;
  endfunction

endpackage

// File: rtl/tsq_queue_ctx.sv
module tsq_queue_ctx #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          take,
  input  logic [AW-1:0] take_next,
  input  logic          take_eol,
  output logic [AW-1:0] head,
  output logic          valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      valid <= 1'b0;
    end else if (take) begin
      head  <= take_next;
      valid <= !take_eol;
    end else if (start && !valid) begin
      head  <= start_addr;
      valid <= 1'b1;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && valid && !take) |=> $stable(head)); // R1

  AST_TAKE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (head == $past(take_next)) && (valid == !$past(take_eol))); // R5

endmodule

// File: rtl/tsq_arbiter.sv
module tsq_arbiter
  import tsq_pkg::*;
(
  input  logic   preempt_en,
  input  tsq_q_e last_q,
  input  logic   hi_valid,
  input  logic   lo_valid,
  output logic   grant,
  output tsq_q_e grant_q
);

  assign grant   = hi_valid | lo_valid;
  assign grant_q = tsq_pick(preempt_en, last_q, hi_valid, lo_valid);

endmodule

// File: rtl/tx_dualq_sched.sv
module tx_dualq_sched
  import tsq_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preempt_en,
  input  logic          hp_start,
  input  logic [AW-1:0] hp_start_addr,
  input  logic          lp_start,
  input  logic [AW-1:0] lp_start_addr,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic [AW-1:0] fetch_next,
  input  logic [LW-1:0] fetch_len,
  input  logic          fetch_eol,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [LW-1:0] cmd_len,
  output logic          cmd_hp,
  input  logic          cmd_done,
  output logic          done_valid,
  output logic [AW-1:0] done_addr,
  output logic          done_hp,
  input  logic          ptr_rd,
  output logic [AW-1:0] ptr_addr,
  output logic          ptr_empty
);

  localparam int NQ = 2;

  // queue contexts
  logic          q_start [NQ];
  logic [AW-1:0] q_saddr [NQ];
  logic          q_take  [NQ];
  logic [AW-1:0] q_head  [NQ];
  logic          q_valid [NQ];

  // named internal events
  tsq_st_e       state;
  tsq_q_e        last_q, cur_q, f_q, grant_q, take_q;
  logic          grant, sel_fire, use_pf, pf_issue;
  logic          ack_ok, ack_drop, take_from_fetch, take_fire;
  logic          f_spec, f_stale;
  logic          pf_valid, pf_eol;
  logic [AW-1:0] pf_addr, pf_next, sel_head, take_addr, take_next, cur_addr;
  logic [LW-1:0] pf_len, take_len, cur_len;
  logic          take_eol;

  assign q_start[0] = hp_start;
  assign q_saddr[0] = hp_start_addr;
  assign q_start[1] = lp_start;
  assign q_saddr[1] = lp_start_addr;

  for (genvar gi = 0; gi < NQ; gi++) begin : g_queue
    assign q_take[gi] = take_fire && (take_q == ((gi == 0) ? Q_HI : Q_LO));
    tsq_queue_ctx #(.AW(AW)) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (q_start[gi]),
      .start_addr (q_saddr[gi]),
      .take       (q_take[gi]),
      .take_next  (take_next),
      .take_eol   (take_eol),
      .head       (q_head[gi]),
      .valid      (q_valid[gi])
    );
  end

  tsq_arbiter u_arb (
    .preempt_en (preempt_en),
    .last_q     (last_q),
    .hi_valid   (q_valid[0]),
    .lo_valid   (q_valid[1]),
    .grant      (grant),
    .grant_q    (grant_q)
  );

  // selection waits for any prefetch still on the port
  assign sel_fire = (state == ST_IDLE) && !fetch_req && grant;
  assign sel_head = (grant_q == Q_HI) ? q_head[0] : q_head[1];
  assign use_pf   = sel_fire && (grant_q == Q_HI) && pf_valid;
  assign pf_issue = (state == ST_RUN) && !fetch_req && !pf_valid && q_valid[0];

  // a fence read poisons any urgent response in or after its cycle
  assign ack_ok   = fetch_req && fetch_ack && !((f_q == Q_HI) && (f_stale || ptr_rd));
  assign ack_drop = fetch_req && fetch_ack && !ack_ok;

  assign take_from_fetch = (state == ST_FETCH) && ack_ok && !f_spec;
  assign take_fire = use_pf || take_from_fetch;
  assign take_q    = use_pf ? Q_HI    : f_q;
  assign take_addr = use_pf ? pf_addr : fetch_addr;
  assign take_next = use_pf ? pf_next : fetch_next;
  assign take_len  = use_pf ? pf_len  : fetch_len;
  assign take_eol  = use_pf ? pf_eol  : fetch_eol;

  // fetch port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
      f_q        <= Q_HI;
      f_spec     <= 1'b0;
      f_stale    <= 1'b0;
    end else if (sel_fire && !use_pf) begin
      fetch_req  <= 1'b1;
      fetch_addr <= sel_head;
      f_q        <= grant_q;
      f_spec     <= 1'b0;
      f_stale    <= 1'b0;
    end else if (pf_issue) begin
      fetch_req  <= 1'b1;
      fetch_addr <= q_head[0];
      f_q        <= Q_HI;
      f_spec     <= 1'b1;
      f_stale    <= 1'b0;
    end else if (fetch_req && fetch_ack) begin
      fetch_req  <= ack_drop && !f_spec;   // re-read a poisoned demand fetch
      f_stale    <= 1'b0;
    end else if (fetch_req && ptr_rd && (f_q == Q_HI)) begin
      f_stale    <= 1'b1;
    end
  end

  // one-entry prefetch of the urgent head
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
      pf_next  <= '0;
      pf_len   <= '0;
      pf_eol   <= 1'b0;
    end else if (ptr_rd || use_pf) begin
      pf_valid <= 1'b0;
    end else if (ack_ok && f_spec) begin
      pf_valid <= 1'b1;
      pf_addr  <= fetch_addr;
      pf_next  <= fetch_next;
      pf_len   <= fetch_len;
      pf_eol   <= fetch_eol;
    end
  end

  // command sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      last_q     <= Q_HI;
      cur_q      <= Q_HI;
      cur_addr   <= '0;
      cur_len    <= '0;
      done_valid <= 1'b0;
      done_addr  <= '0;
      done_hp    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (use_pf) state <= ST_RUN;
                  else if (sel_fire) state <= ST_FETCH;
        ST_FETCH: if (take_from_fetch) state <= ST_RUN;
        ST_RUN:   if (cmd_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
      if (take_fire) begin
        cur_addr <= take_addr;
        cur_len  <= take_len;
        cur_q    <= take_q;
        last_q   <= take_q;
      end
      done_valid <= (state == ST_RUN) && cmd_done;
      done_addr  <= cur_addr;
      done_hp    <= (cur_q == Q_HI);
    end
  end

  assign cmd_valid = (state == ST_RUN);
  assign cmd_addr  = cur_addr;
  assign cmd_len   = cur_len;
  assign cmd_hp    = (cur_q == Q_HI);
  assign ptr_addr  = q_head[0];
  assign ptr_empty = !q_valid[0];

  AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fire && preempt_en && q_valid[0]) |-> (grant_q == Q_HI)); // R2

  AST_STICKY_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fire && !preempt_en && ((last_q == Q_HI) ? q_valid[0] : q_valid[1]))
      |-> (grant_q == last_q)); // R3

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)); // R4

  AST_FENCE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd |=> !pf_valid); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done) |=> done_valid && (done_addr == $past(cmd_addr))); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> fetch_req && $stable(fetch_addr)); // R9

  AST_PF_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (q_valid[0] && (pf_addr == q_head[0]))); // R10

endmodule

// File: tb/tx_dualq_sched_bench.sv
module tx_dualq_sched_bench;

  localparam int AW = 8;
  localparam int LW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic          rst_n = 1'b0;
  logic          preempt_en = 1'b1;
  logic          hp_start = 1'b0, lp_start = 1'b0;
  logic [AW-1:0] hp_start_addr = '0, lp_start_addr = '0;
  logic          fetch_req, fetch_ack = 1'b0, fetch_eol = 1'b0;
  logic [AW-1:0] fetch_addr, fetch_next = '0;
  logic [LW-1:0] fetch_len = '0;
  logic          cmd_valid, cmd_hp, cmd_done = 1'b0;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic          done_valid, done_hp;
  logic [AW-1:0] done_addr;
  logic          ptr_rd = 1'b0;
  logic [AW-1:0] ptr_addr;
  logic          ptr_empty;

  tx_dualq_sched #(.AW(AW), .LW(LW)) u_tx_dualq_sched (
    .clk(clk), .rst_n(rst_n), .preempt_en(preempt_en),
    .hp_start(hp_start), .hp_start_addr(hp_start_addr),
    .lp_start(lp_start), .lp_start_addr(lp_start_addr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_next(fetch_next), .fetch_len(fetch_len), .fetch_eol(fetch_eol),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_hp(cmd_hp), .cmd_done(cmd_done),
    .done_valid(done_valid), .done_addr(done_addr), .done_hp(done_hp),
    .ptr_rd(ptr_rd), .ptr_addr(ptr_addr), .ptr_empty(ptr_empty)
  );

  // memory of command blocks
  logic [AW-1:0] m_next [256];
  logic [LW-1:0] m_len  [256];
  logic          m_eol  [256];

  // reference model: index 0 urgent, 1 normal
  logic [AW-1:0] mh_head [2];
  bit            mh_val  [2];
  int            m_last = 0;

  int n_chk = 0, n_bad = 0, cyc = 0, mac_len = 6;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  function automatic int want_q(bit pre, int last, bit hv, bit lv);
    int q;
    q = -1;
    if (hv || lv) begin
      if (pre || last == 0) q = hv ? 0 : 1;
      else                  q = lv ? 1 : 0;
    end
    return q;
  endfunction

  // start strobes as the design saw them at the edge
  logic          cap_hs = 1'b0, cap_ls = 1'b0;
  logic [AW-1:0] cap_ha = '0, cap_la = '0;
  always @(posedge clk) begin
    cap_hs <= hp_start; cap_ha <= hp_start_addr;
    cap_ls <= lp_start; cap_la <= lp_start_addr;
  end

  // fetch responder: ack two cycles into each request
  int mcnt = 0;
  always @(negedge clk) begin
    if (fetch_ack) begin
      fetch_ack = 1'b0;
      mcnt = 0;
    end else if (fetch_req) begin
      mcnt++;
      if (mcnt >= 2) begin
        fetch_ack  = 1'b1;
        fetch_next = m_next[fetch_addr];
        fetch_len  = m_len[fetch_addr];
        fetch_eol  = m_eol[fetch_addr];
      end
    end
  end

  // monitor, model and MAC
  bit            prev_cv = 0, done_drv = 0, cur_hp = 0;
  logic [AW-1:0] prev_addr = '0, cur_taken = '0;
  int            run_cnt = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
    if (rst_n) begin
      if (cap_hs && !mh_val[0]) begin mh_head[0] = cap_ha; mh_val[0] = 1; end
      if (cap_ls && !mh_val[1]) begin mh_head[1] = cap_la; mh_val[1] = 1; end
      // R8 completion pulse
      if (done_drv)
        chk(done_valid && done_addr == cur_taken && done_hp == cur_hp, "R8 done",
            {done_valid, done_addr}, {1'b1, cur_taken});
      else
        chk(!done_valid, "R8 no pulse", done_valid, 0);
      // R4 no preemption inside a block
      if (prev_cv && !done_drv)
        chk(cmd_valid && cmd_addr == prev_addr, "R4 hold", cmd_addr, prev_addr);
      // take of a new block
      if (cmd_valid && !prev_cv) begin
        int q;
        logic [AW-1:0] ea;
        q = want_q(preempt_en, m_last, mh_val[0], mh_val[1]);
        if (q < 0) begin
          chk(0, "R2 unexpected take", cmd_addr, 0);
        end else begin
          ea = mh_head[q];
          chk(cmd_addr == ea && cmd_hp == (q == 0), preempt_en ? "R2 order" : "R3 order",
              cmd_addr, ea);
          chk(cmd_len == m_len[ea], "R5/R7 length", cmd_len, m_len[ea]);
          mh_head[q] = m_next[ea];
          mh_val[q]  = !m_eol[ea];
          m_last     = q;
          cur_taken  = ea;
          cur_hp     = (q == 0);
        end
        run_cnt = 0;
      end
      chk(ptr_addr == mh_head[0] && ptr_empty == !mh_val[0], "R6 pointer",
          {ptr_empty, ptr_addr}, {!mh_val[0], mh_head[0]});
      if (fetch_req)
        chk((mh_val[0] && fetch_addr == mh_head[0]) || (mh_val[1] && fetch_addr == mh_head[1]),
            "R10 fetch address", fetch_addr, mh_head[0]);
      // MAC model
      if (done_drv) begin
        cmd_done = 1'b0;
        done_drv = 0;
      end else if (cmd_valid) begin
        run_cnt++;
        if (run_cnt >= mac_len) begin
          cmd_done = 1'b1;
          done_drv = 1;
        end
      end
      prev_cv   = cmd_valid;
      prev_addr = cmd_addr;
    end
  end

  task automatic mk(input int a, input int nx, input int len, input bit eol);
    m_next[a] = AW'(nx); m_len[a] = LW'(len); m_eol[a] = eol;
  endtask

  task automatic start_hp(input int a);
    @(negedge clk); hp_start = 1'b1; hp_start_addr = AW'(a);
    @(negedge clk); hp_start = 1'b0;
  endtask

  task automatic start_lp(input int a);
    @(negedge clk); lp_start = 1'b1; lp_start_addr = AW'(a);
    @(negedge clk); lp_start = 1'b0;
  endtask

  task automatic wait_cmd();
    for (int i = 0; i < 200 && !cmd_valid; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    for (int i = 0; i < 3000 && quiet < 4; i++) begin
      @(negedge clk);
      if (!cmd_valid && !fetch_req && !mh_val[0] && !mh_val[1]) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_next[i] = '0; m_len[i] = '0; m_eol[i] = 1'b1;
    end
    mh_head[0] = '0; mh_head[1] = '0; mh_val[0] = 0; mh_val[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // reset state (R6)
    chk(ptr_empty && ptr_addr == 0, "R6 reset pointer", {ptr_empty, ptr_addr}, 9'h100);
    chk(!cmd_valid && !fetch_req && !done_valid, "R9 reset idle", {cmd_valid, fetch_req}, 0);

    // normal queue alone, then urgent alone (R5, R6 empty address)
    mk(8'h40, 8'h44, 12'h010, 0); mk(8'h44, 8'h48, 12'h020, 0); mk(8'h48, 8'h4C, 12'h030, 1);
    start_lp(8'h40);
    wait_idle();
    mk(8'h10, 8'h14, 12'h101, 0); mk(8'h14, 8'h18, 12'h102, 1);
    start_hp(8'h10);
    wait_idle();
    chk(ptr_empty && ptr_addr == 8'h18, "R6 empty append address", ptr_addr, 8'h18);

    // preemption on: urgent work overtakes older normal work (R2), restart ignored (R1)
    mac_len = 20;
    mk(8'h50, 8'h54, 12'h051, 0); mk(8'h54, 8'h58, 12'h052, 0); mk(8'h58, 8'h5C, 12'h053, 1);
    mk(8'h20, 8'h24, 12'h021, 0); mk(8'h24, 8'h28, 12'h022, 1);
    start_lp(8'h50);
    wait_cmd();
    start_hp(8'h20);
    start_hp(8'h77);
    chk(ptr_addr == 8'h20 && !ptr_empty, "R1 strobe on valid queue ignored", ptr_addr, 8'h20);
    wait_idle();
    chk(ptr_addr == 8'h28, "R6 empty after urgent chain", ptr_addr, 8'h28);

    // preemption off: normal queue runs dry first (R3)
    preempt_en = 1'b0;
    mac_len = 8;
    mk(8'h60, 8'h64, 12'h061, 0); mk(8'h64, 8'h68, 12'h062, 0); mk(8'h68, 8'h6C, 12'h063, 1);
    mk(8'h30, 8'h34, 12'h031, 0); mk(8'h34, 8'h38, 12'h032, 1);
    start_lp(8'h60);
    wait_cmd();
    start_hp(8'h30);
    wait_idle();

    // fence: rewrite an urgent block after reading the pointer (R7)
    preempt_en = 1'b1;
    mac_len = 30;
    mk(8'h70, 8'h74, 12'h071, 1);
    mk(8'h80, 8'h84, 12'h011, 0); mk(8'h84, 8'h88, 12'h012, 0); mk(8'h88, 8'h8C, 12'h013, 1);
    start_lp(8'h70);
    wait_cmd();
    start_hp(8'h80);
    repeat (10) @(negedge clk);
    @(negedge clk);
    ptr_rd = 1'b1;
    chk(ptr_addr == 8'h80, "R7 fence read value", ptr_addr, 8'h80);
    mk(8'h80, 8'h90, 12'h155, 0);
    mk(8'h90, 8'h94, 12'h033, 1);
    @(negedge clk);
    ptr_rd = 1'b0;
    wait_idle();
    chk(ptr_addr == 8'h94 && ptr_empty, "R7 rewritten chain followed", ptr_addr, 8'h94);

    // fence during an urgent demand fetch (R7, R9)
    mac_len = 4;
    mk(8'hA0, 8'hA4, 12'h0A1, 1);
    start_hp(8'hA0);
    @(negedge clk);
    ptr_rd = 1'b1;
    mk(8'hA0, 8'hB0, 12'h0AA, 0);
    mk(8'hB0, 8'hB4, 12'h0B1, 1);
    @(negedge clk);
    ptr_rd = 1'b0;
    wait_idle();
    chk(ptr_addr == 8'hB4 && ptr_empty, "R7 demand fetch re-read", ptr_addr, 8'hB4);

    finish_run();
  end

endmodule